// File: doc/BRIEF.md
# Embedded Operations Channel Message Processor

This block sits behind the overhead-bit extractor of a 2B1Q loop transceiver. Each superframe delivers one 12-bit maintenance word. The word carries a 3-bit address, a flag that marks it as a message, and an 8-bit code. The block filters each word, then waits until the same word has arrived three times in a row. Only then does it treat the message as confirmed. A confirmed message is decoded into local maintenance actions: a full 2B+D loopback, a loopback of one B channel, or a request to corrupt the transmitted CRC.

Every confirmed message is also latched as an echo word, even when its code has no local meaning. The next superframe tick then raises a one-cycle strobe, so that the transmit side can send the echo back upstream. The action flags hold their state until a synchronous reset clears them.

Top module: `eoc_msg_proc`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows all four action flags at 0, `echo_vld` at 0 and `echo_word` at 0, and the repetition count is cleared.
- R2: A word strobed with `eoc_word[11:9]` other than 3'b000 or 3'b111 is discarded. It does not change the flags or the echo, and it does not break or advance the repetition count.
- R3: A word strobed with the message flag `eoc_word[8]` at 0 (a data word) is discarded in the same way as in R2.
- R4: A message is confirmed on the third consecutive accepted word with identical address, flag and code, and its action is visible in the cycle after that third strobe. An accepted word that differs from the previous accepted word restarts the count at one.
- R5: Further identical accepted words after a confirmation do not confirm the message again. A new confirmation needs a different word repeated three times.
- R6: A confirmed code 8'h50 sets `lb_full` and clears `lb_b1` and `lb_b2`.
- R7: A confirmed code 8'h51 sets `lb_b1` and clears `lb_full` and `lb_b2`.
- R8: A confirmed code 8'h52 sets `lb_b2` and clears `lb_full` and `lb_b1`.
- R9: A confirmed code 8'h53 sets `crc_corrupt` and leaves the loopback flags unchanged. At most one loopback flag is ever high.
- R10: A confirmed code outside 8'h50..8'h53 changes no flag. Like every confirmed message, it loads the full 12-bit word into `echo_word`, which then holds until the next confirmation.
- R11: `echo_vld` is high for exactly one cycle, one cycle after the first `sf_tick` that is sampled after a confirmation has registered. A tick sampled in the same cycle as the confirming strobe does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sf_tick | input | 1 | Superframe boundary pulse |
| eoc_vld | input | 1 | Strobe for eoc_word |
| eoc_word | input | 12 | Address [11:9], message flag [8], code [7:0] |
| lb_full | output | 1 | 2B+D loopback active |
| lb_b1 | output | 1 | B1 loopback active |
| lb_b2 | output | 1 | B2 loopback active |
| crc_corrupt | output | 1 | Corrupt transmitted CRC |
| echo_vld | output | 1 | One-cycle strobe: echo_word to be sent |
| echo_word | output | 12 | Last confirmed word |

## Verification
The hardest situation to reach from the ports is a confirmation that is interleaved with discarded words. Three accepted identical words must arrive while filtered words are mixed in between them. Purely random words almost never repeat three times, so the random stimulus draws from a small pool of addresses, flags and codes and repeats the previous word most of the time. This produces long identical runs, broken now and then by wrong-address and data words. Directed sequences then place a discarded word inside a run, repeat a word past confirmation, and put a tick in the same cycle as the confirming strobe.

// File: rtl/eoc_msg_proc.sv
module eoc_msg_proc #(
  parameter int AW     = 3,
  parameter int CW     = 8,
  parameter int REPEAT = 3,
  parameter logic [CW-1:0] C_LB_ALL = 8'h50,
  parameter logic [CW-1:0] C_LB_B1  = 8'h51,
  parameter logic [CW-1:0] C_LB_B2  = 8'h52,
  parameter logic [CW-1:0] C_CRC    = 8'h53
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sf_tick,
  input  logic             eoc_vld,
  input  logic [AW+CW:0]   eoc_word,
  output logic             lb_full,
  output logic             lb_b1,
  output logic             lb_b2,
  output logic             crc_corrupt,
  output logic             echo_vld,
  output logic [AW+CW:0]   echo_word
);
  localparam int W  = AW + CW + 1;
  localparam int NW = $clog2(REPEAT + 1);
  localparam logic [NW-1:0] CMAX = NW'(REPEAT);
  localparam logic [NW-1:0] CFIRE = NW'(REPEAT - 1);

  logic [NW-1:0] cnt;
  logic [W-1:0]  last;
  logic          pend;

  wire [AW-1:0] addr    = eoc_word[W-1 -: AW];
  wire [CW-1:0] code    = eoc_word[CW-1:0];
  wire          addr_ok = (addr == '0) || (addr == '1);
  wire          acc     = eoc_vld && addr_ok && eoc_word[CW];
  wire          same    = (cnt != '0) && (eoc_word == last);
  wire          confirm = acc && same && (cnt == CFIRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      last <= '0;
      pend <= 1'b0;
      lb_full <= 1'b0;
      lb_b1 <= 1'b0;
      lb_b2 <= 1'b0;
      crc_corrupt <= 1'b0;
      echo_vld <= 1'b0;
      echo_word <= '0;
    end else begin
      if (acc) begin
        if (same) begin
          if (cnt != CMAX) cnt <= cnt + 1'b1;
        end else begin
          last <= eoc_word;
          cnt <= NW'(1);
        end
      end
      if (confirm) begin
        echo_word <= eoc_word;
        case (code)
          C_LB_ALL: begin lb_full <= 1'b1; lb_b1 <= 1'b0; lb_b2 <= 1'b0; end
          C_LB_B1:  begin lb_full <= 1'b0; lb_b1 <= 1'b1; lb_b2 <= 1'b0; end
          C_LB_B2:  begin lb_full <= 1'b0; lb_b1 <= 1'b0; lb_b2 <= 1'b1; end
          C_CRC:    crc_corrupt <= 1'b1;
          default:  ;
        endcase
      end
      pend <= confirm || (pend && !sf_tick);
      echo_vld <= pend && sf_tick;
    end
  end
endmodule

// File: rtl/eoc_msg_proc_chk.sv
module eoc_msg_proc_chk (
  input logic        clk,
  input logic        rst,
  input logic        sf_tick,
  input logic        eoc_vld,
  input logic [11:0] eoc_word,
  input logic        lb_full,
  input logic        lb_b1,
  input logic        lb_b2,
  input logic        crc_corrupt,
  input logic        echo_vld,
  input logic [11:0] echo_word
);
  wire drop = eoc_vld && (!eoc_word[8] || !(eoc_word[11:9] == 3'b000 || eoc_word[11:9] == 3'b111));

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !lb_full && !lb_b1 && !lb_b2 && !crc_corrupt && !echo_vld); // R1
  AST_DROP_NO_EFFECT: assert property (@(posedge clk) disable iff (rst) drop |=> $stable({lb_full, lb_b1, lb_b2, crc_corrupt, echo_word})); // R2
  AST_ONE_LOOPBACK: assert property (@(posedge clk) disable iff (rst) $countones({lb_full, lb_b1, lb_b2}) <= 1); // R9
  AST_B1_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(lb_b1) |-> $past(eoc_vld) && $past(eoc_word[7:0]) == 8'h51); // R7
  AST_FULL_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(lb_full) |-> $past(eoc_vld) && $past(eoc_word[7:0]) == 8'h50); // R6
  AST_ECHO_AFTER_TICK: assert property (@(posedge clk) disable iff (rst) echo_vld |-> $past(sf_tick)); // R11
endmodule

bind eoc_msg_proc eoc_msg_proc_chk u_chk (.*);

// File: tb/sim_eoc_msg_proc.sv
module sim_eoc_msg_proc;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sf_tick = 1'b0;
  logic eoc_vld = 1'b0;
  logic [11:0] eoc_word = '0;
  logic lb_full, lb_b1, lb_b2, crc_corrupt, echo_vld;
  logic [11:0] echo_word;

  int total = 0;
  int bad = 0;

  logic [1:0] m_cnt;
  logic [11:0] m_last, m_echo;
  logic m_full, m_b1, m_b2, m_crc, m_pend, m_ev;

  always #5 clk = ~clk;

  eoc_msg_proc u0 (.clk, .rst, .sf_tick, .eoc_vld, .eoc_word, .lb_full, .lb_b1, .lb_b2,
                   .crc_corrupt, .echo_vld, .echo_word);

  function automatic logic accepted(input logic v, input logic [11:0] w);
    return v && w[8] && (w[11:9] == 3'b000 || w[11:9] == 3'b111);
  endfunction

  function automatic logic [16:0] pack_exp();
    return {m_full, m_b1, m_b2, m_crc, m_ev, m_echo};
  endfunction

  task automatic compare(input string tag);
    logic [16:0] act;
    act = {lb_full, lb_b1, lb_b2, crc_corrupt, echo_vld, echo_word};
    total++;
    if (act !== pack_exp()) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, pack_exp());
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_last = 0; m_echo = 0;
    m_full = 0; m_b1 = 0; m_b2 = 0; m_crc = 0; m_pend = 0; m_ev = 0;
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1; eoc_vld = 1'b0; sf_tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
    model_reset();
    compare(tag);
    rst = 1'b0;
  endtask

  task automatic step(input logic v, input logic [11:0] w, input logic t, input string tag);
    logic conf, same;
    eoc_vld = v; eoc_word = w; sf_tick = t;
    same = (m_cnt != 0) && (w == m_last);
    conf = accepted(v, w) && same && (m_cnt == 2);
    m_ev = m_pend && t;
    m_pend = conf || (m_pend && !t);
    if (accepted(v, w)) begin
      if (same) begin
        if (m_cnt != 3) m_cnt = m_cnt + 1;
      end else begin
        m_last = w; m_cnt = 1;
      end
    end
    if (conf) begin
      m_echo = w;
      case (w[7:0])
        8'h50: begin m_full = 1; m_b1 = 0; m_b2 = 0; end
        8'h51: begin m_full = 0; m_b1 = 1; m_b2 = 0; end
        8'h52: begin m_full = 0; m_b1 = 0; m_b2 = 1; end
        8'h53: m_crc = 1;
        default: ;
      endcase
    end
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [11:0] mk(input logic [2:0] a, input logic f, input logic [7:0] c);
    return {a, f, c};
  endfunction

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [11:0] w;
    void'($urandom(32'd1234));
    model_reset();
    @(negedge clk);
    do_reset("R1 reset state");

    step(1, mk(3'b000, 1, 8'h50), 0, "R4 first");
    step(1, mk(3'b000, 1, 8'h50), 0, "R4 second no action");
    step(1, mk(3'b000, 1, 8'h50), 1, "R6 full loopback, R11 same-cycle tick ignored");
    step(0, 12'h0, 0, "R11 no echo yet");
    step(0, 12'h0, 1, "R11 tick");
    step(0, 12'h0, 0, "R11 echo pulse");
    step(0, 12'h0, 0, "R11 pulse ends");
    step(1, mk(3'b000, 1, 8'h50), 1, "R5 fourth repeat");
    step(0, 12'h0, 1, "R5 no second echo");
    step(0, 12'h0, 0, "R5 quiet");

    step(1, mk(3'b111, 1, 8'h51), 0, "R7 first");
    step(1, mk(3'b011, 1, 8'h51), 0, "R2 bad address inside run");
    step(1, mk(3'b111, 0, 8'h51), 0, "R3 data word inside run");
    step(1, mk(3'b111, 1, 8'h51), 0, "R2 second");
    step(1, mk(3'b111, 1, 8'h51), 0, "R7 b1 loopback clears full");

    step(1, mk(3'b000, 1, 8'h52), 0, "R4 restart");
    step(1, mk(3'b000, 1, 8'h53), 0, "R4 different word restarts");
    step(1, mk(3'b000, 1, 8'h52), 0, "R4 restart again");
    step(1, mk(3'b000, 1, 8'h52), 0, "R4 two");
    step(1, mk(3'b000, 1, 8'h52), 0, "R8 b2 loopback");

    for (int i = 0; i < 3; i++) step(1, mk(3'b111, 1, 8'h53), 0, "R9 crc corrupt");
    for (int i = 0; i < 3; i++) step(1, mk(3'b000, 1, 8'hA5), 0, "R10 unknown code");
    step(0, 12'h0, 1, "R10 tick");
    step(0, 12'h0, 0, "R10 echo of unknown");
    for (int i = 0; i < 3; i++) step(1, mk(3'b101, 1, 8'h50), 0, "R2 bad address run");
    for (int i = 0; i < 3; i++) step(1, mk(3'b000, 0, 8'h51), 0, "R3 data run");

    do_reset("R1 reset clears set flags");

    w = mk(3'b000, 1, 8'h50);
    for (int i = 0; i < 1500; i++) begin
      logic [2:0] a;
      logic [7:0] c;
      if (($urandom % 10) >= 7) begin
        case ($urandom % 4)
          0: a = 3'b000; 1: a = 3'b111; 2: a = 3'b000; default: a = 3'($urandom);
        endcase
        case ($urandom % 6)
          0: c = 8'h50; 1: c = 8'h51; 2: c = 8'h52; 3: c = 8'h53;
          4: c = 8'hFF; default: c = 8'($urandom);
        endcase
        w = mk(a, ($urandom % 8) != 0, c);
      end
      step(($urandom % 4) != 0, w, ($urandom % 6) == 0, "R4 random mix");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule